// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer with 4 MiB Superpages

This block is a small, fully associative translation cache for a two-level, 32-bit paging scheme. It holds recently used virtual-to-physical page mappings so that most memory accesses avoid a page walk. A lookup presents a 20-bit virtual page number and the 9-bit address-space identifier of the running context. In the same cycle, the block answers with a hit flag, the 22-bit physical page number, the seven permission and status bits of the leaf entry, and a flag that marks a superpage hit.

An external page walker installs results through the fill port. A fill carries the page number, the identifier, the physical page number, the permission bits and a superpage flag. A superpage maps 4 MiB, so only the upper ten bits of the virtual page number take part in its tag compare. The flush port clears the whole buffer, or only the non-global mappings of one address space. Entries marked global match under every identifier.

Fills and flushes take effect at the clock edge. A lookup always sees the contents as they stood before that edge.

Top module: `tlb_asid_cache`

## Requirements
- R1: After reset, no lookup hits until a fill has been made.
- R2: Only a valid entry can hit. A filled mapping becomes visible to lookups from the cycle after the fill edge and not in the fill cycle. On a miss, the physical page number, the permission bits and the superpage flag are all zero.
- R3: A non-global entry hits only when the lookup identifier equals the identifier stored with it.
- R4: An entry whose global permission bit is set hits under any lookup identifier.
- R5: A superpage entry compares only virtual page number bits 19:10. On a superpage hit, physical page number bits 9:0 are copied from lookup virtual page number bits 9:0, bits 21:10 come from the entry, and the superpage flag is 1.
- R6: The permission field is returned exactly as filled, with the encoding bit0 read, bit1 write, bit2 execute, bit3 user, bit4 global, bit5 accessed, bit6 dirty.
- R7: A fill that does not replace an existing mapping goes to the lowest-numbered invalid entry when one exists. In that case no valid mapping is evicted.
- R8: When all 8 entries are valid, a fill replaces the entry named by a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping, only on such a replacement.
- R9: A fill with the same virtual page number (upper ten bits only for a superpage), the same size and the same identifier as a valid entry overwrites that entry and does not create a second one.
- R10: A flush with the select-all input at 0 invalidates only the valid entries that are non-global and whose identifier equals the flush identifier.
- R11: A flush with the select-all input at 1 invalidates every entry.
- R12: When a flush and a fill fall in the same cycle, the flush is applied first, so the newly filled mapping is valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 9 | Lookup address-space identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 22 | Physical page number of the hit, zero on a miss |
| lk_perm | output | 7 | Permission bits of the hit (R6 encoding), zero on a miss |
| lk_super | output | 1 | Hit came from a superpage entry |
| fill_en | input | 1 | Install a mapping at this edge |
| fill_vpn | input | 20 | Virtual page number of the mapping |
| fill_asid | input | 9 | Identifier of the mapping |
| fill_ppn | input | 22 | Physical page number of the mapping |
| fill_perm | input | 7 | Permission bits of the mapping |
| fill_super | input | 1 | Mapping is a 4 MiB superpage |
| flush_en | input | 1 | Invalidate at this edge |
| flush_all | input | 1 | 1: all entries, 0: non-global entries of flush_asid |
| flush_asid | input | 9 | Identifier for the selective flush |

## Verification
A flush and a fill can land on the same clock edge, and a lookup can arrive in the very cycle that a fill is pending. The bench drives a full flush together with a fill. It also drives a selective flush of one identifier together with an overwriting fill in that same space. In both cases it judges the outcome by lookups in the following cycle: the new mapping must hit and the older mappings must miss. For the pending-fill case, it looks up the page being filled in the fill cycle itself and expects a miss, then expects a hit one cycle later.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, permission bit positions and the stored entry type
// for the translation cache. Assumes a two-level 32-bit paging scheme.
package tlb_pkg;
    localparam int VPN_W  = 20;
    localparam int PPN_W  = 22;
    localparam int ASID_W = 9;
    localparam int PERM_W = 7;
    localparam int LO_W   = 10;          // page-number bits covered by a superpage

    // permission bit positions
    localparam int PB_R = 0;
    localparam int PB_W = 1;
    localparam int PB_X = 2;
    localparam int PB_U = 3;
    localparam int PB_G = 4;
    localparam int PB_A = 5;
    localparam int PB_D = 6;

    typedef struct packed {
        logic              valid;
        logic              sup;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
    } tlb_ent_t;
endpackage

// File: rtl/tlb_way_cmp.sv
`timescale 1ns/1ps
// Module: tag comparison for one entry. Produces the lookup hit (identifier
// match or global override, size-aware tag) and the fill same-page match
// (same size, same tag, same identifier). Assumes the stored low tag bits of
// a superpage are don't-care.
module tlb_way_cmp
    import tlb_pkg::*;
(
    input  logic              ent_valid,
    input  logic              ent_sup,
    input  logic              ent_glob,
    input  logic [ASID_W-1:0] ent_asid,
    input  logic [VPN_W-1:0]  ent_vpn,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_super,
    output logic              hit,
    output logic              same_page
);
    logic lk_tag_eq;
    logic fill_tag_eq;

    // size-aware tag compare for lookup and fill
    always_comb begin
        lk_tag_eq = (ent_vpn[VPN_W-1:LO_W] == lk_vpn[VPN_W-1:LO_W]) &&
                    (ent_sup || (ent_vpn[LO_W-1:0] == lk_vpn[LO_W-1:0]));
        fill_tag_eq = (ent_vpn[VPN_W-1:LO_W] == fill_vpn[VPN_W-1:LO_W]) &&
                      (ent_sup || (ent_vpn[LO_W-1:0] == fill_vpn[LO_W-1:0]));
    end

    // qualify with valid bit and identifier
    always_comb begin
        hit       = ent_valid && lk_tag_eq && (ent_glob || (ent_asid == lk_asid));
        same_page = ent_valid && fill_tag_eq && (ent_sup == fill_super) &&
                    (ent_asid == fill_asid);
    end
endmodule

// File: rtl/tlb_repl.sv
`timescale 1ns/1ps
// Module: fill slot choice. Picks the lowest invalid entry, else the
// round-robin pointer. Assumes the pointer is kept below N_ENT by the owner.
module tlb_repl #(
    parameter int N_ENT = 8,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0] valid_v,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] victim,
    output logic             full
);
    logic             any_free;
    logic [IDX_W-1:0] free_idx;

    // priority search for the lowest free slot
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!valid_v[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // choose between free slot and rotating victim
    always_comb begin
        full   = !any_free;
        victim = any_free ? free_idx : rr_ptr;
    end
endmodule

// File: rtl/tlb_asid_cache.sv
`timescale 1ns/1ps
// Module: fully associative translation cache with identifier tags, global
// override and 4 MiB superpages. Lookup is combinational from the stored
// entries; fill and flush act on the rising edge, flush first. Assumes the
// caller never relies on a lookup seeing a fill in its own cycle.
module tlb_asid_cache
    import tlb_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [PERM_W-1:0] lk_perm,
    output logic              lk_super,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              fill_super,
    input  logic              flush_en,
    input  logic              flush_all,
    input  logic [ASID_W-1:0] flush_asid
);
    tlb_ent_t         tbl [N_ENT];
    logic [N_ENT-1:0] hit_v;
    logic [N_ENT-1:0] same_v;
    logic [N_ENT-1:0] valid_v;
    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] victim;
    logic             full;
    logic             hit_any;
    logic [IDX_W-1:0] hit_idx;
    logic             same_any;
    logic [IDX_W-1:0] same_idx;
    logic [IDX_W-1:0] tgt;
    tlb_ent_t         new_ent;
    tlb_ent_t         sel_ent;

    // one comparator per entry
    for (genvar g = 0; g < N_ENT; g++) begin : g_way
        assign valid_v[g] = tbl[g].valid;
        tlb_way_cmp u_cmp (
            .ent_valid (tbl[g].valid),
            .ent_sup   (tbl[g].sup),
            .ent_glob  (tbl[g].perm[PB_G]),
            .ent_asid  (tbl[g].asid),
            .ent_vpn   (tbl[g].vpn),
            .lk_vpn    (lk_vpn),
            .lk_asid   (lk_asid),
            .fill_vpn  (fill_vpn),
            .fill_asid (fill_asid),
            .fill_super(fill_super),
            .hit       (hit_v[g]),
            .same_page (same_v[g])
        );
    end

    tlb_repl #(.N_ENT(N_ENT)) u_repl (
        .valid_v(valid_v),
        .rr_ptr (rr_ptr),
        .victim (victim),
        .full   (full)
    );

    // lowest-index hit and same-page selection
    always_comb begin
        hit_any  = 1'b0;
        hit_idx  = '0;
        same_any = 1'b0;
        same_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_v[i]) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (same_v[i]) begin
                same_any = 1'b1;
                same_idx = IDX_W'(i);
            end
        end
    end

    // lookup result, superpage low bits taken from the request
    always_comb begin
        sel_ent  = tbl[hit_idx];
        lk_hit   = hit_any;
        lk_super = hit_any && sel_ent.sup;
        lk_perm  = hit_any ? sel_ent.perm : '0;
        if (!hit_any)
            lk_ppn = '0;
        else if (sel_ent.sup)
            lk_ppn = {sel_ent.ppn[PPN_W-1:LO_W], lk_vpn[LO_W-1:0]};
        else
            lk_ppn = sel_ent.ppn;
    end

    // entry image and slot for a fill
    always_comb begin
        new_ent.valid = 1'b1;
        new_ent.sup   = fill_super;
        new_ent.asid  = fill_asid;
        new_ent.vpn   = fill_super ? {fill_vpn[VPN_W-1:LO_W], {LO_W{1'b0}}} : fill_vpn;
        new_ent.ppn   = fill_ppn;
        new_ent.perm  = fill_perm;
        tgt           = same_any ? same_idx : victim;
    end

    // state update: reset, then flush, then fill (fill wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) tbl[i] <= '0;
            rr_ptr <= '0;
        end else begin
            if (flush_en) begin
                for (int i = 0; i < N_ENT; i++) begin
                    if (flush_all || (!tbl[i].perm[PB_G] && tbl[i].asid == flush_asid))
                        tbl[i].valid <= 1'b0;
                end
            end
            if (fill_en) begin
                tbl[tgt] <= new_ent;
                if (!same_any && full)
                    rr_ptr <= (rr_ptr == IDX_W'(N_ENT - 1)) ? '0 : rr_ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlb_asid_cache_chk.sv
`timescale 1ns/1ps
// Module: port-level properties of the translation cache, bound to the top.
// Assumes the synchronous active-low reset of the top.
module tlb_asid_cache_chk
    import tlb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic [ASID_W-1:0] lk_asid,
    input logic              lk_hit,
    input logic [PPN_W-1:0]  lk_ppn,
    input logic [PERM_W-1:0] lk_perm,
    input logic              lk_super,
    input logic              fill_en,
    input logic [VPN_W-1:0]  fill_vpn,
    input logic [ASID_W-1:0] fill_asid,
    input logic              flush_en,
    input logic              flush_all
);
    // empty right after reset
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !lk_hit);

    // a fill is visible at the next cycle under its own page and identifier
    assert_fill_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fill_en) && lk_vpn == $past(fill_vpn) &&
         lk_asid == $past(fill_asid)) |-> lk_hit);

    // a miss drives all result fields to zero
    assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_ppn == '0 && lk_perm == '0 && !lk_super));

    // superpage result carries the request low bits
    assert_super_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_super |-> (lk_hit && lk_ppn[LO_W-1:0] == lk_vpn[LO_W-1:0]));

    // a full flush without a fill leaves nothing to hit
    assert_full_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flush_en) && $past(flush_all) && !$past(fill_en))
        |-> !lk_hit);
endmodule

bind tlb_asid_cache tlb_asid_cache_chk u_chk (.*);

// File: tb/tb_tlb_asid_cache.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own lookups.
module tb_tlb_asid_cache;
    import tlb_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [VPN_W-1:0]  lk_vpn = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic              lk_hit;
    logic [PPN_W-1:0]  lk_ppn;
    logic [PERM_W-1:0] lk_perm;
    logic              lk_super;
    logic              fill_en = 1'b0;
    logic [VPN_W-1:0]  fill_vpn = '0;
    logic [ASID_W-1:0] fill_asid = '0;
    logic [PPN_W-1:0]  fill_ppn = '0;
    logic [PERM_W-1:0] fill_perm = '0;
    logic              fill_super = 1'b0;
    logic              flush_en = 1'b0;
    logic              flush_all = 1'b0;
    logic [ASID_W-1:0] flush_asid = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    tlb_asid_cache dut (.*);

    // drive one edge of fill and/or flush, then release
    task automatic edge_op(input bit do_fill, input logic [VPN_W-1:0] v,
                           input logic [ASID_W-1:0] a, input logic [PPN_W-1:0] p,
                           input logic [PERM_W-1:0] pm, input bit sp,
                           input bit do_flush, input bit all, input logic [ASID_W-1:0] fa);
        @(negedge clk);
        fill_en = do_fill; fill_vpn = v; fill_asid = a; fill_ppn = p;
        fill_perm = pm; fill_super = sp;
        flush_en = do_flush; flush_all = all; flush_asid = fa;
        @(negedge clk);
        fill_en = 1'b0; flush_en = 1'b0;
    endtask

    task automatic fill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                        input logic [PPN_W-1:0] p, input logic [PERM_W-1:0] pm, input bit sp);
        edge_op(1'b1, v, a, p, pm, sp, 1'b0, 1'b0, '0);
    endtask

    task automatic flush(input bit all, input logic [ASID_W-1:0] fa);
        edge_op(1'b0, '0, '0, '0, '0, 1'b0, 1'b1, all, fa);
    endtask

    // combinational lookup, sampled 1 ns after driving, away from edges
    task automatic look(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                        input bit eh, input logic [PPN_W-1:0] ep,
                        input logic [PERM_W-1:0] epm, input bit es, input string req);
        lk_vpn = v; lk_asid = a;
        #1;
        n_chk++;
        if (lk_hit !== eh || (eh && (lk_ppn !== ep || lk_perm !== epm || lk_super !== es))) begin
            n_bad++;
            $display("FAIL %s vpn=%h asid=%0d: hit=%b ppn=%h perm=%h sup=%b expected hit=%b ppn=%h perm=%h sup=%b",
                     req, v, a, lk_hit, lk_ppn, lk_perm, lk_super, eh, ep, epm, es);
        end
    endtask

    task automatic t_reset;
        look(20'h00000, 9'd0, 1'b0, '0, '0, 1'b0, "R1");
        look(20'h12345, 9'd3, 1'b0, '0, '0, 1'b0, "R1");
    endtask

    // slot choice: free slot first, then round robin from 0
    task automatic t_replace;
        for (int k = 0; k < 8; k++)
            fill(20'h00100 + 20'(k), (k == 5) ? 9'd2 : 9'd1, 22'h1000 + 22'(k), 7'h23, 1'b0);
        flush(1'b0, 9'd2);
        look(20'h00105, 9'd2, 1'b0, '0, '0, 1'b0, "R10");
        fill(20'h00200, 9'd1, 22'h2000, 7'h23, 1'b0);
        for (int k = 0; k < 8; k++)
            if (k != 5) look(20'h00100 + 20'(k), 9'd1, 1'b1, 22'h1000 + 22'(k), 7'h23, 1'b0, "R7");
        look(20'h00200, 9'd1, 1'b1, 22'h2000, 7'h23, 1'b0, "R7");
        fill(20'h00201, 9'd1, 22'h2001, 7'h23, 1'b0);
        look(20'h00100, 9'd1, 1'b0, '0, '0, 1'b0, "R8");
        look(20'h00101, 9'd1, 1'b1, 22'h1001, 7'h23, 1'b0, "R8");
        fill(20'h00202, 9'd1, 22'h2002, 7'h23, 1'b0);
        look(20'h00101, 9'd1, 1'b0, '0, '0, 1'b0, "R8");
        look(20'h00102, 9'd1, 1'b1, 22'h1002, 7'h23, 1'b0, "R8");
        look(20'h00202, 9'd1, 1'b1, 22'h2002, 7'h23, 1'b0, "R8");
        flush(1'b1, '0);
        look(20'h00102, 9'd1, 1'b0, '0, '0, 1'b0, "R11");
        look(20'h00201, 9'd1, 1'b0, '0, '0, 1'b0, "R11");
    endtask

    // identifier qualification, global override, permission passthrough
    task automatic t_asid;
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = 20'h00300; fill_asid = 9'd7;
        fill_ppn = 22'h003AB; fill_perm = 7'h0B; fill_super = 1'b0;
        look(20'h00300, 9'd7, 1'b0, '0, '0, 1'b0, "R2");   // not yet visible
        @(negedge clk);
        fill_en = 1'b0;
        look(20'h00300, 9'd7, 1'b1, 22'h003AB, 7'h0B, 1'b0, "R6");
        look(20'h00300, 9'd6, 1'b0, '0, '0, 1'b0, "R3");
        look(20'h00302, 9'd7, 1'b0, '0, '0, 1'b0, "R2");
        fill(20'h00301, 9'd7, 22'h0ABCD, 7'h55, 1'b0);
        look(20'h00301, 9'd300, 1'b1, 22'h0ABCD, 7'h55, 1'b0, "R4");
        look(20'h00301, 9'd7, 1'b1, 22'h0ABCD, 7'h55, 1'b0, "R4");
        flush(1'b1, '0);
    endtask

    // 4 MiB entries compare only the upper ten bits
    task automatic t_super;
        fill({10'h2A5, 10'h000}, 9'd3, {12'hABC, 10'h000}, 7'h27, 1'b1);
        look({10'h2A5, 10'h1F3}, 9'd3, 1'b1, {12'hABC, 10'h1F3}, 7'h27, 1'b1, "R5");
        look({10'h2A5, 10'h3FF}, 9'd3, 1'b1, {12'hABC, 10'h3FF}, 7'h27, 1'b1, "R5");
        look({10'h2A4, 10'h1F3}, 9'd3, 1'b0, '0, '0, 1'b0, "R5");
        flush(1'b1, '0);
    endtask

    // refill of an existing page replaces it in place
    task automatic t_dup;
        fill(20'h00400, 9'd1, 22'h00011, 7'h03, 1'b0);
        fill(20'h00400, 9'd1, 22'h00022, 7'h61, 1'b0);
        look(20'h00400, 9'd1, 1'b1, 22'h00022, 7'h61, 1'b0, "R9");
        for (int k = 1; k < 8; k++) fill(20'h00400 + 20'(k), 9'd1, 22'h00500 + 22'(k), 7'h03, 1'b0);
        look(20'h00400, 9'd1, 1'b1, 22'h00022, 7'h61, 1'b0, "R9");
        look(20'h00407, 9'd1, 1'b1, 22'h00507, 7'h03, 1'b0, "R9");
        flush(1'b1, '0);
    endtask

    // selective flush spares global and other spaces
    task automatic t_flush_asid;
        fill(20'h00500, 9'd3, 22'h00050, 7'h03, 1'b0);
        fill(20'h00501, 9'd3, 22'h00051, 7'h13, 1'b0);
        fill(20'h00502, 9'd4, 22'h00052, 7'h03, 1'b0);
        flush(1'b0, 9'd3);
        look(20'h00500, 9'd3, 1'b0, '0, '0, 1'b0, "R10");
        look(20'h00501, 9'd3, 1'b1, 22'h00051, 7'h13, 1'b0, "R10");
        look(20'h00502, 9'd4, 1'b1, 22'h00052, 7'h03, 1'b0, "R10");
        flush(1'b1, '0);
    endtask

    // flush and fill on one edge: fill survives
    task automatic t_same_cycle;
        fill(20'h00600, 9'd1, 22'h00060, 7'h03, 1'b0);
        edge_op(1'b1, 20'h00601, 9'd1, 22'h00061, 7'h03, 1'b0, 1'b1, 1'b1, '0);
        look(20'h00600, 9'd1, 1'b0, '0, '0, 1'b0, "R12");
        look(20'h00601, 9'd1, 1'b1, 22'h00061, 7'h03, 1'b0, "R12");
        edge_op(1'b1, 20'h00601, 9'd1, 22'h00071, 7'h07, 1'b0, 1'b1, 1'b0, 9'd1);
        look(20'h00601, 9'd1, 1'b1, 22'h00071, 7'h07, 1'b0, "R12");
        flush(1'b1, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_replace();
        t_asid();
        t_super();
        t_dup();
        t_flush_asid();
        t_same_cycle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule